// File: doc/BRIEF.md
# UART Frame Engine

This block is the character framing core of a serial port. On the transmit side it takes bytes from a queue, wraps each one in a low start bit and a high stop bit, and shifts the data out least significant bit first on an idle-high line. On the receive side it watches the serial input, confirms a start bit, assembles the data bits and hands each completed character out with a one-cycle strobe. Parity, break detection and modem lines are not part of it.

Bit timing comes from an external oversampling tick that pulses sixteen times per bit period. The number of data bits, from five to eight, is chosen at run time through a 2-bit code. A control word carries a global enable and one enable for each direction. The engine reads the control word and the width code only between characters. Clearing an enable while a character is on the line therefore never cuts that character short. The engine finishes it and then stays idle.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset the serial output is high, the queue pop strobe is low and the receive strobe is low.
- R2: A transmitted character is a low start bit, then the data bits least significant first, then one high stop bit, each lasting 16 ticks. The line is high between characters.
- R3: Width code `wlen_i` selects the data bit count in both directions: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. A received character is right-aligned in `rx_data_o` with the unused upper bits zero.
- R4: The width code is captured when a character begins, and a change during the character has no effect on it.
- R5: The transmitter pops one byte, as a single-cycle `txq_pop_o` pulse, only when it is idle, `ctrl_i[0]` and `ctrl_i[8]` are both 1, and `txq_empty_i` is 0. Otherwise it pops nothing and the line stays high.
- R6: If `ctrl_i[0]` or `ctrl_i[8]` drops during a transmitted character, that character still completes unchanged and no further byte is popped.
- R7: The receiver checks the line again on the 8th tick after it sees a falling edge. If the line is high by then, it abandons the start and produces no output.
- R8: Each received data bit is sampled 16 ticks after the previous sample. If the stop bit is sampled high, the character is presented on `rx_data_o` together with a one-cycle `rx_valid_o` pulse.
- R9: A character whose stop bit is sampled low is discarded and produces no `rx_valid_o` pulse. The receiver then goes back to looking for a start bit.
- R10: Reception starts only when `ctrl_i[0]` and `ctrl_i[9]` are both 1. If either one drops during a character, that character is still completed and delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit period |
| ctrl_i | input | 16 | Control word: bit 0 global enable, bit 8 transmit enable, bit 9 receive enable |
| wlen_i | input | 2 | Data width code (5 to 8 bits) |
| txq_empty_i | input | 1 | Transmit queue has no byte |
| txq_data_i | input | 8 | Byte at the head of the transmit queue |
| txq_pop_o | output | 1 | One-cycle pulse removing the head byte |
| txd_o | output | 1 | Serial output line |
| rxd_i | input | 1 | Serial input line |
| rx_data_o | output | 8 | Last received character, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe marking a new character |

## Verification
A transmit shift register or bit counter that goes wrong shows up within one bit period, 16 ticks, as a wrong line level at the middle of a bit. It can also show up as a stop bit that lands in the wrong position for the selected width. A receive state machine that has lost its place is caught within one character time. It either raises a strobe it should not raise, for example after a glitch or a low stop bit, or it misses a strobe or delivers a mis-aligned value. Problems in the enable logic appear at the queue interface: a pop pulse that happens while disabled, or a missing pop, is visible in the cycle after the decision.

// File: rtl/uart_frame_pkg.sv
`timescale 1ns/1ps
package uart_frame_pkg;

  // Control word bit positions, decoded by neighbouring logic
  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_TX_BIT = 8;
  localparam int unsigned CTRL_RX_BIT = 9;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } frame_state_e;

  // Width code to data bit count: 0 -> 5 ... 3 -> 8
  function automatic logic [3:0] width_of(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx
  import uart_frame_pkg::*;
#(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go,
  input  logic [1:0]        wlen,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  output logic              q_pop,
  output logic              txd
);

  localparam int unsigned TCW = $clog2(OSR);
  localparam int unsigned BCW = $clog2(DATA_W + 1);
  localparam logic [TCW-1:0] T_LAST = TCW'(OSR - 1);

  frame_state_e      state;
  logic [TCW-1:0]    tcnt;
  logic [BCW-1:0]    bcnt;
  logic [BCW-1:0]    nbits;
  logic [DATA_W-1:0] shreg;
  logic              bit_end;

  assign bit_end = tick && (tcnt == T_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_IDLE;
      tcnt  <= '0;
      bcnt  <= '0;
      nbits <= BCW'(DATA_W);
      shreg <= '0;
      q_pop <= 1'b0;
      txd   <= 1'b1;
    end else begin
      q_pop <= 1'b0;
      if (tick && state != FR_IDLE) tcnt <= bit_end ? '0 : tcnt + 1'b1;
      case (state)
        FR_IDLE: begin
          txd <= 1'b1;
          if (go && !q_empty) begin
            q_pop <= 1'b1;
            shreg <= q_data;
            nbits <= BCW'(width_of(wlen));
            tcnt  <= '0;
            bcnt  <= '0;
            txd   <= 1'b0;
            state <= FR_START;
          end
        end
        FR_START: begin
          if (bit_end) begin
            txd   <= shreg[0];
            state <= FR_DATA;
          end
        end
        FR_DATA: begin
          if (bit_end) begin
            if (bcnt == nbits - 1'b1) begin
              txd   <= 1'b1;
              state <= FR_STOP;
            end else begin
              bcnt  <= bcnt + 1'b1;
              shreg <= shreg >> 1;
              txd   <= shreg[1];
            end
          end
        end
        FR_STOP: begin
          if (bit_end) state <= FR_IDLE;
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  // R5
  pop_gate_chk: assert property (@(posedge clk) disable iff (rst)
    q_pop |-> $past(go && !q_empty));

  // R5
  pop_single_chk: assert property (@(posedge clk) disable iff (rst)
    q_pop |=> !q_pop);

  // R4
  tx_width_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != FR_IDLE && $past(state) != FR_IDLE) |-> $stable(nbits));

  // R2
  tx_start_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(q_pop) |-> !txd);

endmodule

// File: rtl/uart_frame_rx.sv
`timescale 1ns/1ps
module uart_frame_rx
  import uart_frame_pkg::*;
#(
  parameter int unsigned OSR       = 16,
  parameter int unsigned SAMPLE_AT = 8,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go,
  input  logic [1:0]        wlen,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  localparam int unsigned TCW = $clog2(OSR);
  localparam int unsigned BCW = $clog2(DATA_W + 1);
  localparam logic [TCW-1:0] T_LAST = TCW'(OSR - 1);
  localparam logic [TCW-1:0] T_MID  = TCW'(SAMPLE_AT - 1);

  frame_state_e      state;
  logic [1:0]        sync;
  logic              line;
  logic [TCW-1:0]    tcnt;
  logic [BCW-1:0]    bcnt;
  logic [BCW-1:0]    nbits;
  logic [DATA_W-1:0] shreg;

  assign line = sync[1];

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FR_IDLE;
      tcnt     <= '0;
      bcnt     <= '0;
      nbits    <= BCW'(DATA_W);
      shreg    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        FR_IDLE: begin
          if (go && !line) begin
            tcnt  <= '0;
            bcnt  <= '0;
            nbits <= BCW'(width_of(wlen));
            state <= FR_START;
          end
        end
        FR_START: begin
          if (tick) begin
            if (tcnt == T_MID) begin
              tcnt  <= '0;
              state <= line ? FR_IDLE : FR_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        FR_DATA: begin
          if (tick) begin
            if (tcnt == T_LAST) begin
              tcnt  <= '0;
              shreg <= {line, shreg[DATA_W-1:1]};
              if (bcnt == nbits - 1'b1) state <= FR_STOP;
              else                      bcnt  <= bcnt + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        FR_STOP: begin
          if (tick) begin
            if (tcnt == T_LAST) begin
              state <= FR_IDLE;
              if (line) begin
                rx_data  <= shreg >> (DATA_W - 32'(nbits));
                rx_valid <= 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: state <= FR_IDLE;
      endcase
    end
  end

  // R8
  rx_stop_high_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(line));

  // R8
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R4
  rx_width_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != FR_IDLE && $past(state) != FR_IDLE) |-> $stable(nbits));

  // R7
  rx_start_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == FR_START && state == FR_DATA) |-> !$past(line));

endmodule

// File: rtl/uart_frame_engine.sv
`timescale 1ns/1ps
module uart_frame_engine
  import uart_frame_pkg::*;
#(
  parameter int unsigned OSR       = 16,
  parameter int unsigned SAMPLE_AT = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [1:0]        wlen_i,
  input  logic              txq_empty_i,
  input  logic [DATA_W-1:0] txq_data_i,
  output logic              txq_pop_o,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);

  logic tx_go;
  logic rx_go;

  assign tx_go = ctrl_i[CTRL_EN_BIT] && ctrl_i[CTRL_TX_BIT];
  assign rx_go = ctrl_i[CTRL_EN_BIT] && ctrl_i[CTRL_RX_BIT];

  uart_frame_tx #(.OSR(OSR), .DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_i),
    .go      (tx_go),
    .wlen    (wlen_i),
    .q_empty (txq_empty_i),
    .q_data  (txq_data_i),
    .q_pop   (txq_pop_o),
    .txd     (txd_o)
  );

  uart_frame_rx #(.OSR(OSR), .SAMPLE_AT(SAMPLE_AT), .DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_i),
    .go       (rx_go),
    .wlen     (wlen_i),
    .rxd      (rxd_i),
    .rx_data  (rx_data_o),
    .rx_valid (rx_valid_o)
  );

endmodule

// File: tb/uart_frame_engine_tb.sv
`timescale 1ns/1ps
module uart_frame_engine_tb;

  localparam logic [15:0] C_ALL  = 16'h0301;
  localparam logic [15:0] C_NOTX = 16'h0201;
  localparam logic [15:0] C_NOEN = 16'h0300;
  localparam logic [15:0] C_NORX = 16'h0101;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] ctrl = 16'h0000;
  logic [1:0]  wlen = 2'd3;
  logic        rxd = 1'b1;
  logic        txq_empty;
  logic [7:0]  txq_data;
  logic        txq_pop;
  logic        txd;
  logic [7:0]  rx_data;
  logic        rx_valid;

  logic [7:0] qmem [8];
  int qhead = 0;
  int qtail = 0;
  int pops = 0;
  int got_cnt = 0;
  logic [7:0] got_data = '0;
  int n_checks = 0;
  int n_fail = 0;
  int tdiv = 0;
  bit done = 0;

  assign txq_empty = (qhead == qtail);
  assign txq_data  = qmem[qhead[2:0]];

  uart_frame_engine u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .ctrl_i(ctrl), .wlen_i(wlen),
    .txq_empty_i(txq_empty), .txq_data_i(txq_data), .txq_pop_o(txq_pop),
    .txd_o(txd), .rxd_i(rxd), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  initial forever begin
    @(negedge clk);
    if (txq_pop) begin qhead = qhead + 1; pops = pops + 1; end
    if (rx_valid) begin got_cnt = got_cnt + 1; got_data = rx_data; end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    qmem[qtail[2:0]] = b;
    qtail = qtail + 1;
  endtask

  task automatic capture_tx(input int n, output logic [7:0] d, output bit ok);
    int guard = 0;
    bit st;
    d = '0;
    while (txd !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    wait_ticks(8);
    st = (txd == 1'b0);
    for (int i = 0; i < n; i++) begin
      wait_ticks(16);
      d[i] = txd;
    end
    wait_ticks(16);
    ok = st && (txd == 1'b1);
  endtask

  task automatic send_rx(input logic [7:0] d, input int n, input bit bad_stop);
    rxd = 1'b0;
    wait_ticks(16);
    for (int i = 0; i < n; i++) begin
      rxd = d[i];
      wait_ticks(16);
    end
    if (bad_stop) begin
      rxd = 1'b0; wait_ticks(12); rxd = 1'b1; wait_ticks(20);
    end else begin
      rxd = 1'b1; wait_ticks(16);
    end
    wait_ticks(4);
  endtask

  task automatic t_reset();
    check("R1 txd idle", 32'(txd), 32'd1);
    check("R1 pop low", 32'(txq_pop), 32'd0);
    check("R1 rx strobe low", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_tx_basic();
    logic [7:0] d; bit ok;
    ctrl = C_ALL; wlen = 2'd3;
    push(8'hA5);
    capture_tx(8, d, ok);
    check("R2 8-bit data", 32'(d), 32'hA5);
    check("R2 start/stop", 32'(ok), 32'd1);
    check("R5 one pop", 32'(pops), 32'd1);
    wait_ticks(10);
    check("R2 idle high", 32'(txd), 32'd1);
  endtask

  task automatic t_tx_short();
    logic [7:0] d; bit ok;
    wlen = 2'd0;
    push(8'h3B);
    capture_tx(5, d, ok);
    check("R3 5-bit tx data", 32'(d), 32'h1B);
    check("R3 5-bit stop position", 32'(ok), 32'd1);
    wait_ticks(10);
    wlen = 2'd3;
  endtask

  task automatic t_tx_gate();
    logic [7:0] d; bit ok; int p0;
    p0 = pops;
    ctrl = C_NOTX;
    push(8'h6C);
    wait_ticks(50);
    check("R5 no pop tx disabled", 32'(pops - p0), 32'd0);
    check("R5 line high tx disabled", 32'(txd), 32'd1);
    ctrl = C_NOEN;
    wait_ticks(50);
    check("R5 no pop global disabled", 32'(pops - p0), 32'd0);
    ctrl = C_ALL;
    capture_tx(8, d, ok);
    check("R5 sends once enabled", 32'(d), 32'h6C);
  endtask

  task automatic t_tx_stop_mid();
    logic [7:0] d; bit ok; int p0;
    p0 = pops;
    push(8'h0F); push(8'h96);
    fork
      capture_tx(8, d, ok);
      begin wait_ticks(40); ctrl = C_NOTX; end
    join
    check("R6 char completes", 32'(d), 32'h0F);
    check("R6 framing intact", 32'(ok), 32'd1);
    wait_ticks(60);
    check("R6 no further pop", 32'(pops - p0), 32'd1);
    check("R6 line idle", 32'(txd), 32'd1);
    ctrl = C_ALL;
    capture_tx(8, d, ok);
    check("R6 next byte after re-enable", 32'(d), 32'h96);
  endtask

  task automatic t_tx_width_change();
    logic [7:0] d; bit ok;
    wlen = 2'd3;
    push(8'hC3);
    fork
      capture_tx(8, d, ok);
      begin wait_ticks(30); wlen = 2'd0; end
    join
    check("R4 width held tx", 32'(d), 32'hC3);
    check("R4 stop after 8 bits", 32'(ok), 32'd1);
    wlen = 2'd3;
    wait_ticks(10);
  endtask

  task automatic t_rx_basic();
    int c0 = got_cnt;
    ctrl = C_ALL; wlen = 2'd3;
    send_rx(8'h5A, 8, 1'b0);
    check("R8 rx strobe", 32'(got_cnt - c0), 32'd1);
    check("R8 rx data", 32'(got_data), 32'h5A);
  endtask

  task automatic t_rx_six();
    int c0 = got_cnt;
    wlen = 2'd1;
    send_rx(8'hED, 6, 1'b0);
    check("R3 6-bit rx strobe", 32'(got_cnt - c0), 32'd1);
    check("R3 6-bit rx aligned", 32'(got_data), 32'h2D);
    wlen = 2'd3;
  endtask

  task automatic t_rx_glitch();
    int c0 = got_cnt;
    rxd = 1'b0; wait_ticks(3); rxd = 1'b1; wait_ticks(40);
    check("R7 glitch rejected", 32'(got_cnt - c0), 32'd0);
    send_rx(8'h81, 8, 1'b0);
    check("R7 recovers after glitch", 32'(got_data), 32'h81);
  endtask

  task automatic t_rx_badstop();
    int c0 = got_cnt;
    send_rx(8'h33, 8, 1'b1);
    check("R9 low stop discarded", 32'(got_cnt - c0), 32'd0);
    send_rx(8'h4E, 8, 1'b0);
    check("R9 next char accepted", 32'(got_cnt - c0), 32'd1);
    check("R9 next char data", 32'(got_data), 32'h4E);
  endtask

  task automatic t_rx_gate_and_stop();
    int c0 = got_cnt;
    ctrl = C_NORX;
    send_rx(8'h77, 8, 1'b0);
    check("R10 rx disabled ignores", 32'(got_cnt - c0), 32'd0);
    ctrl = C_ALL;
    fork
      send_rx(8'hB4, 8, 1'b0);
      begin wait_ticks(50); ctrl = C_NOEN; end
    join
    check("R10 rx completes after disable", 32'(got_cnt - c0), 32'd1);
    check("R10 rx data after disable", 32'(got_data), 32'hB4);
    send_rx(8'h19, 8, 1'b0);
    check("R10 stays stopped", 32'(got_cnt - c0), 32'd1);
    ctrl = C_ALL;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_short();
    t_tx_gate();
    t_tx_stop_mid();
    t_tx_width_change();
    t_rx_basic();
    t_rx_six();
    t_rx_glitch();
    t_rx_badstop();
    t_rx_gate_and_stop();
    finish_run();
  end

endmodule